// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Freeze Buffer

This block sits on the receive side of a T1 framer, behind framing recovery. It picks the robbed signaling bits out of the received PCM stream: the least significant bit of each channel in every sixth frame. Each multiframe's A/B (D4) or A/B/C/D (ESF) set is gathered per channel. The block commits the finished set into a delay line at the multiframe boundary and drives the set back out serially, three multiframes later, in the low nibble of each channel slot. The whole block runs on a bit-rate clock. The framer supplies the channel and bit counters and the frame and multiframe strobes.

When freezing is enabled, a loss of frame sync, a carrier loss or a frame slip stops all commits, so the output keeps its last good signaling. A force input freezes unconditionally. A freeze flag reports that a freeze is in effect. After the fault clears, a frame-counting hold-off keeps the old state for a mode-dependent time before updates resume.

The controller has three states. ST_LIVE moves to ST_FAULT when an enabled fault is present. ST_FAULT moves to ST_HOLD when the fault clears. ST_HOLD moves back to ST_FAULT if a fault returns. ST_HOLD moves to ST_LIVE when the hold count is used up. From any state, a low freeze-enable returns the controller to ST_LIVE.

Top module: `sig_freeze_buf`

## Requirements
- R1: After reset, `frozen` is low and `sig_out` is low in every bit slot until signaling has passed through the delay line.
- R2: The frame number restarts at 1 on `mf_sync` and advances on each `frame_sync`. At `bit_idx`=7, `sig_in` is stored per channel as A in frame 6 and B in frame 12, and in ESF mode also as C in frame 18 and D in frame 24.
- R3: Signaling captured during multiframe k is presented during multiframe k+3 when no freeze intervenes. The presented value changes only at the clock edge that ends an `mf_sync` cycle.
- R4: In each channel, `bit_idx` 0..3 (bits 1..4) output 0. In ESF mode, `bit_idx` 4..7 output A, B, C, D. In D4 mode they output A, B, A, B.
- R5: With `frz_en` high, a high `los_sync`, `carrier_loss` or `slip` drives `frozen` high from the next cycle on.
- R6: `frz_force` high drives `frozen` high in the same cycle, whatever the fault inputs and `frz_en` are.
- R7: While `frozen` is high, no multiframe commit takes place, and every channel's output stays the same across multiframe boundaries.
- R8: After the fault clears, `frozen` stays high until the clock edge of the 73rd `frame_sync` in ESF mode (`esf_mode`=1), or the 37th in D4 mode. This gives at least 72 or 36 whole frames (9 ms or 4.5 ms).
- R9: A fault that returns during the hold-off goes back to ST_FAULT. The hold-off count then starts again from zero once that fault clears.
- R10: With `frz_en` low, the fault inputs have no effect: `frozen` follows `frz_force` only, and commits continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the first bit cycle of each frame |
| mf_sync | input | 1 | High in the first bit cycle of each multiframe (with frame_sync) |
| chan_idx | input | CH_W | Current channel, 0..NUM_CH-1 |
| bit_idx | input | 3 | Bit within channel, 0 = bit 1 (MSB), 7 = bit 8 (LSB) |
| sig_in | input | 1 | Received PCM data bit |
| los_sync | input | 1 | Loss of frame synchronisation |
| carrier_loss | input | 1 | Loss of carrier |
| slip | input | 1 | Frame slip event |
| frz_en | input | 1 | Enables fault-triggered freezing |
| frz_force | input | 1 | Forces a freeze |
| esf_mode | input | 1 | 1 = ESF (24-frame multiframe), 0 = D4 (12-frame) |
| sig_out | output | 1 | Serial signaling aligned to channel timing |
| frozen | output | 1 | Freeze in effect |

## Verification
The hardest case to reach from the ports is the exact end of the hold-off. The bench must release the fault on a known frame boundary. It must also place a second fault partway through the hold, so that an off-by-one exit or a timer that fails to restart stands out. The scenario does this by driving the fault inputs on the falling edge of a frame-strobe cycle. It then counts strobes and samples `frozen` on the last strobe cycle and on the cycle after it, in both framing modes. A behavioural model compares the serial output on every clock. Frame snapshots taken across multiframe boundaries show that a forced freeze holds the output and that D4 mode repeats the bit pairs.

// File: rtl/sfz_pkg.sv
package sfz_pkg;
    typedef enum logic [1:0] {
        ST_LIVE  = 2'd0,
        ST_FAULT = 2'd1,
        ST_HOLD  = 2'd2
    } frz_state_e;

    localparam int SIG_BITS    = 4;
    localparam int SIG_SPACING = 6;
    localparam int BIT_W       = 3;

    typedef logic [SIG_BITS-1:0] sig_nib_t;
endpackage

// File: rtl/sfz_capture.sv
module sfz_capture
    import sfz_pkg::*;
#(
    parameter int NUM_CH    = 24,
    parameter int CH_W      = 5,
    parameter int MF_FRAMES = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_sync,
    input  logic                       mf_sync,
    input  logic [CH_W-1:0]            chan_idx,
    input  logic [BIT_W-1:0]           bit_idx,
    input  logic                       sig_in,
    input  logic                       esf_mode,
    output logic [NUM_CH*SIG_BITS-1:0] cap_flat
);
    localparam int FRM_W = $clog2(MF_FRAMES + 1);
    localparam logic [BIT_W-1:0] LSB_SLOT = BIT_W'(7);

    logic [FRM_W-1:0] frame_no;
    logic             slot_hit;
    logic [1:0]       slot_pos;

    // frame numbering, restarted by the multiframe strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_no <= '0;
        end else if (mf_sync) begin
            frame_no <= FRM_W'(1);
        end else if (frame_sync && frame_no != '0 && frame_no < FRM_W'(MF_FRAMES)) begin
            frame_no <= frame_no + 1'b1;
        end
    end

    // which signaling letter, if any, the current bit carries
    always_comb begin
        int ordinal;
        slot_hit = 1'b0;
        slot_pos = 2'd0;
        ordinal  = int'(frame_no) / SIG_SPACING;
        if (bit_idx == LSB_SLOT && frame_no != '0
            && (int'(frame_no) % SIG_SPACING) == 0 && ordinal <= SIG_BITS) begin
            slot_hit = (ordinal <= 2) || esf_mode;
            slot_pos = 2'(SIG_BITS - ordinal);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        sig_nib_t nib_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q <= '0;
            end else if (slot_hit && chan_idx == CH_W'(c)) begin
                nib_q[slot_pos] <= sig_in;
            end
        end
        assign cap_flat[c*SIG_BITS +: SIG_BITS] = nib_q;
    end

    // R2: frame number never runs past the multiframe length
    a_r2_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_no <= FRM_W'(MF_FRAMES));
endmodule

// File: rtl/sfz_delay.sv
module sfz_delay
    import sfz_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5,
    parameter int DEPTH  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mf_sync,
    input  logic                       frz,
    input  logic [NUM_CH*SIG_BITS-1:0] cap_flat,
    input  logic [CH_W-1:0]            chan_idx,
    input  logic [BIT_W-1:0]           bit_idx,
    input  logic                       esf_mode,
    output logic                       sig_out
);
    localparam int LINE_W = NUM_CH * SIG_BITS;

    logic [LINE_W-1:0] stg [DEPTH];
    logic [LINE_W-1:0] tail;
    logic              commit;
    sig_nib_t          cur_nib;

    assign commit = mf_sync && !frz;
    assign tail   = stg[DEPTH-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
        end else if (commit) begin
            stg[0] <= cap_flat;
            for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
        end
    end

    always_comb begin
        cur_nib = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_idx == CH_W'(c)) cur_nib = tail[c*SIG_BITS +: SIG_BITS];
        end
    end

    always_comb begin
        if (!bit_idx[2]) begin
            sig_out = 1'b0;
        end else if (esf_mode) begin
            sig_out = cur_nib[~bit_idx[1:0]];
        end else begin
            sig_out = bit_idx[0] ? cur_nib[2] : cur_nib[3];
        end
    end

    // R7: a freeze blocks the presented line from changing
    a_r7_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> $stable(tail));
    // R3: presented line moves only at a multiframe edge
    a_r3_mf_only: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_sync |=> $stable(tail));
    // R4: upper nibble of every channel is zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx < BIT_W'(4)) |-> !sig_out);
endmodule

// File: rtl/sfz_ctrl.sv
module sfz_ctrl
    import sfz_pkg::*;
#(
    parameter int HOLD_ESF = 72,
    parameter int HOLD_D4  = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_sync,
    input  logic los_sync,
    input  logic carrier_loss,
    input  logic slip,
    input  logic frz_en,
    input  logic frz_force,
    input  logic esf_mode,
    output logic frozen
);
    localparam int HOLD_MAX = (HOLD_ESF > HOLD_D4) ? HOLD_ESF : HOLD_D4;
    localparam int CNT_W    = $clog2(HOLD_MAX + 1);

    frz_state_e       st, st_nxt;
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] hold_lim;
    logic             fault_hit;

    assign fault_hit = frz_en && (los_sync || carrier_loss || slip);
    assign hold_lim  = esf_mode ? CNT_W'(HOLD_ESF) : CNT_W'(HOLD_D4);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_LIVE:  if (fault_hit) st_nxt = ST_FAULT;
            ST_FAULT: if (!fault_hit) st_nxt = ST_HOLD;
            ST_HOLD: begin
                if (fault_hit)                              st_nxt = ST_FAULT;
                else if (frame_sync && hold_cnt >= hold_lim) st_nxt = ST_LIVE;
            end
            default:  st_nxt = ST_LIVE;
        endcase
        if (!frz_en) st_nxt = ST_LIVE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LIVE;
        else        st <= st_nxt;
    end

    // hold-off frame counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (st == ST_HOLD && st_nxt == ST_HOLD) begin
            if (frame_sync) hold_cnt <= hold_cnt + 1'b1;
        end else begin
            hold_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        frozen = (st != ST_LIVE) || frz_force;
    end

    // R5: enabled fault freezes from the next cycle
    a_r5_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_en && (los_sync || carrier_loss || slip)) |=> frozen);
    // R9: fault during hold returns to the fault state
    a_r9_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && frz_en && (los_sync || carrier_loss || slip)) |=> (st == ST_FAULT));
    // R10: disabled freezing always ends in the live state
    a_r10_disabled_live: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_en |=> (st == ST_LIVE));
    // R8: hold counter stays within the longest hold
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= CNT_W'(HOLD_MAX));
    // R8: no early exit from hold
    a_r8_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && frz_en && !(los_sync || carrier_loss || slip)
         && !(frame_sync && hold_cnt >= hold_lim)) |=> (st == ST_HOLD));
endmodule

// File: rtl/sig_freeze_buf.sv
module sig_freeze_buf
    import sfz_pkg::*;
#(
    parameter int NUM_CH    = 24,
    parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int HOLD_ESF  = 72,
    parameter int HOLD_D4   = 36,
    parameter int DELAY_MF  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    input  logic            mf_sync,
    input  logic [CH_W-1:0] chan_idx,
    input  logic [2:0]      bit_idx,
    input  logic            sig_in,
    input  logic            los_sync,
    input  logic            carrier_loss,
    input  logic            slip,
    input  logic            frz_en,
    input  logic            frz_force,
    input  logic            esf_mode,
    output logic            sig_out,
    output logic            frozen
);
    localparam int LINE_W = NUM_CH * SIG_BITS;

    logic [LINE_W-1:0] cap_flat;

    sfz_capture #(.NUM_CH(NUM_CH), .CH_W(CH_W), .MF_FRAMES(24)) u_capture (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mf_sync(mf_sync),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .sig_in(sig_in),
        .esf_mode(esf_mode), .cap_flat(cap_flat)
    );

    sfz_ctrl #(.HOLD_ESF(HOLD_ESF), .HOLD_D4(HOLD_D4)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .los_sync(los_sync),
        .carrier_loss(carrier_loss), .slip(slip), .frz_en(frz_en),
        .frz_force(frz_force), .esf_mode(esf_mode), .frozen(frozen)
    );

    sfz_delay #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DEPTH(DELAY_MF)) u_delay (
        .clk(clk), .rst_n(rst_n), .mf_sync(mf_sync), .frz(frozen),
        .cap_flat(cap_flat), .chan_idx(chan_idx), .bit_idx(bit_idx),
        .esf_mode(esf_mode), .sig_out(sig_out)
    );

    // R6: force freeze shows on the flag at once
    a_r6_force_now: assert property (@(posedge clk) disable iff (!rst_n)
        frz_force |-> frozen);
endmodule

// File: tb/test_sig_freeze_buf.sv
module test_sig_freeze_buf;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;
    localparam int CW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_sync = 1'b0, mf_sync = 1'b0;
    logic [CW-1:0] chan_idx = '0;
    logic [2:0] bit_idx = '0;
    logic sig_in = 1'b0;
    logic los_sync = 1'b0, carrier_loss = 1'b0, slip = 1'b0;
    logic frz_en = 1'b1, frz_force = 1'b0, esf_mode = 1'b1;
    logic esf_sel = 1'b1;
    logic sig_out, frozen;

    int n_tot = 0, n_bad = 0;
    bit gen_go = 0, cmp_on = 0, done = 0;

    always #(CLK_P/2) clk = ~clk;

    sig_freeze_buf #(.NUM_CH(NCH)) i_sig_freeze_buf (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mf_sync(mf_sync),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .sig_in(sig_in),
        .los_sync(los_sync), .carrier_loss(carrier_loss), .slip(slip),
        .frz_en(frz_en), .frz_force(frz_force), .esf_mode(esf_mode),
        .sig_out(sig_out), .frozen(frozen)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // timing generator: coherent frame/channel/bit counters
    initial begin
        wait (gen_go);
        forever begin
            logic mode_nxt;
            int   mflen;
            mode_nxt = esf_sel;
            mflen = mode_nxt ? 24 : 12;
            for (int f = 1; f <= mflen; f++)
                for (int ch = 0; ch < NCH; ch++)
                    for (int b = 0; b < 8; b++) begin
                        @(posedge clk); #1;
                        if (f == 1 && ch == 0 && b == 0) esf_mode = mode_nxt;
                        chan_idx   = CW'(ch);
                        bit_idx    = 3'(b);
                        frame_sync = (ch == 0 && b == 0);
                        mf_sync    = (f == 1 && ch == 0 && b == 0);
                        sig_in     = 1'($urandom_range(0, 1));
                    end
        end
    end

    // behavioural reference model
    int m_st, m_cnt, m_frame;
    logic [3:0] m_cap [NCH];
    logic [3:0] m_q0 [NCH], m_q1 [NCH], m_q2 [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_frame = 0;
            for (int c = 0; c < NCH; c++) begin
                m_cap[c] = 0; m_q0[c] = 0; m_q1[c] = 0; m_q2[c] = 0;
            end
        end else begin
            bit froz, hit;
            int lim, ns;
            froz = (m_st != 0) || frz_force;
            hit  = frz_en && (los_sync || carrier_loss || slip);
            lim  = esf_mode ? 72 : 36;
            if (mf_sync && !froz) begin
                m_q2 = m_q1; m_q1 = m_q0; m_q0 = m_cap;
            end
            if (bit_idx == 7 && m_frame > 0 && m_frame % 6 == 0) begin
                int k;
                k = m_frame / 6;
                if (k <= 2 || esf_mode) m_cap[chan_idx][4 - k] = sig_in;
            end
            if (mf_sync) m_frame = 1;
            else if (frame_sync && m_frame > 0 && m_frame < 24) m_frame++;
            ns = m_st;
            if (m_st == 0 && hit) ns = 1;
            else if (m_st == 1 && !hit) ns = 2;
            else if (m_st == 2) begin
                if (hit) ns = 1;
                else if (frame_sync && m_cnt >= lim) ns = 0;
            end
            if (!frz_en) ns = 0;
            if (m_st == 2 && ns == 2) begin
                if (frame_sync) m_cnt++;
            end else m_cnt = 0;
            m_st = ns;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            logic e_sig;
            logic [3:0] n;
            n = m_q2[chan_idx];
            if (bit_idx < 4)   e_sig = 1'b0;
            else if (esf_mode) e_sig = n[7 - bit_idx];
            else               e_sig = bit_idx[0] ? n[2] : n[3];
            chk("R2 sig_out vs model", 32'(sig_out), 32'(e_sig));
            chk("R8 frozen vs model", 32'(frozen), 32'((m_st != 0) || frz_force));
        end
    end

    task automatic wait_frames(input int n);
        repeat (n) begin
            do @(negedge clk); while (!frame_sync);
        end
    endtask

    task automatic wait_mf();
        do @(negedge clk); while (!mf_sync);
    endtask

    task automatic snap(output logic [31:0] v);
        while (!frame_sync) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            v[i] = sig_out;
            @(negedge clk);
        end
    endtask

    task automatic hold_test(input int hold, input string tag);
        carrier_loss = 1'b1;
        @(negedge clk);
        chk({tag, " R5 frozen after fault"}, 32'(frozen), 32'd1);
        wait_frames(2);
        carrier_loss = 1'b0;
        wait_frames(hold);
        chk({tag, " R8 still frozen at hold end"}, 32'(frozen), 32'd1);
        wait_frames(1);
        chk({tag, " R8 frozen on last strobe"}, 32'(frozen), 32'd1);
        @(negedge clk);
        chk({tag, " R8 released"}, 32'(frozen), 32'd0);
    endtask

    initial begin
        logic [31:0] va, vb;
        repeat (4) @(negedge clk);
        bit_idx = 3'd7;
        #1;
        chk("R1 reset frozen", 32'(frozen), 32'd0);
        chk("R1 reset sig_out", 32'(sig_out), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        gen_go = 1;
        wait_mf();
        cmp_on = 1;
        chk("R1 frozen after reset", 32'(frozen), 32'd0);
        repeat (4) wait_mf();
        // R3: stable within a live multiframe
        snap(va);
        wait_frames(5);
        snap(vb);
        chk("R3 stable inside multiframe", vb, va);

        hold_test(72, "ESF");

        // R9: slip during hold restarts the hold-off
        los_sync = 1'b1;
        wait_frames(1);
        los_sync = 1'b0;
        wait_frames(40);
        slip = 1'b1;
        @(negedge clk);
        slip = 1'b0;
        chk("R9 frozen after slip in hold", 32'(frozen), 32'd1);
        wait_frames(72);
        chk("R9 hold restarted", 32'(frozen), 32'd1);
        wait_frames(1);
        @(negedge clk);
        chk("R9 released after full hold", 32'(frozen), 32'd0);

        // R6/R7: forced freeze across multiframe boundaries
        repeat (4) wait_mf();
        frz_force = 1'b1;
        #1;
        chk("R6 force immediate", 32'(frozen), 32'd1);
        snap(va);
        wait_mf();
        wait_mf();
        snap(vb);
        chk("R7 output held while frozen", vb, va);
        frz_force = 1'b0;

        // R10: faults ignored with freezing disabled
        frz_en = 1'b0;
        los_sync = 1'b1;
        carrier_loss = 1'b1;
        @(negedge clk);
        chk("R10 fault ignored", 32'(frozen), 32'd0);
        wait_mf();
        wait_mf();
        chk("R10 still live", 32'(frozen), 32'd0);
        los_sync = 1'b0;
        carrier_loss = 1'b0;
        frz_en = 1'b1;

        // D4 framing
        esf_sel = 1'b0;
        repeat (5) wait_mf();
        snap(va);
        for (int c = 0; c < NCH; c++) begin
            chk("R4 upper nibble zero", 32'(va[c*8 +: 4]), 32'd0);
            chk("R4 D4 bit5 equals bit7", 32'(va[c*8+4]), 32'(va[c*8+6]));
            chk("R4 D4 bit6 equals bit8", 32'(va[c*8+5]), 32'(va[c*8+7]));
        end
        hold_test(36, "D4");
        repeat (3) wait_mf();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            n_tot++;
            n_bad++;
            $display("FAIL R8 watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end
endmodule